// File: doc/BRIEF.md
# Egress and Pin Timestamp Capture

This block samples a free-running 64-bit time counter when one of two kinds of event occurs. When a port sends a frame, its egress strobe stores the low bits of the counter in that port's stamp register and raises an update flag. Host software polls the flag, and reading the register with the read enable clears it. When the external clock pin changes level in either direction, the full 64-bit time is latched into one sync-stamp register. That register holds only the most recent event. It has no queue and no interrupt.

A parameter selects the stamp width. The narrow variant keeps 24 counter bits, which wrap after roughly 0.135 s. The wide variant keeps 32 bits, which wrap after roughly 34.35 s. The host rebuilds the full time from a partial stamp by reading the counter within one wrap period. That step is not part of this block. Reads go through a combinational word select, and the clearing takes effect at the clock edge of the read.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset every readable word reads zero: all update flags are clear and the sync stamp is zero, so zero means no pin event has occurred yet.
- R2: A high `egr_strobe[p]` at a rising clock edge stores the low stamp bits of `time_now` sampled at that edge into port p's register and sets its flag. The word reads the new value from the next cycle on.
- R3: Narrow variant (`WIDE_STAMP`=0): a port word holds the update flag in bit 0 and the 24-bit stamp in bits 31:8. All other bits are zero.
- R4: Wide variant (`WIDE_STAMP`=1): a port word holds the update flag in bit 0 and the 32-bit stamp in bits 63:32. All other bits are zero.
- R5: A clock edge with `rd_en` high and `rd_addr`=p, and with no strobe on p, clears port p's flag and keeps its stamp. Other ports are not affected.
- R6: When a strobe and a clearing read hit the same port at the same edge, the capture wins: the flag stays set and the stamp takes the new time.
- R7: The pin passes through two synchronising flops. A level change in either direction that is applied before rising edge k makes the sync word equal the `time_now` presented at edge k+2, and the word is readable after that edge.
- R8: Without a pin transition the sync word never changes, and reading it does not clear it.
- R9: A strobe on a port whose flag is already set overwrites the stored stamp. Only the newest capture is kept.
- R10: `rd_addr` values 0 to NPORT-1 select port words, NPORT selects the sync word, and any higher address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | TW | Running time counter |
| egr_strobe | input | NPORT | Per-port frame egress event |
| pin_in | input | 1 | Asynchronous external clock pin |
| rd_en | input | 1 | Read strobe; clears the selected port's flag |
| rd_addr | input | AW | Word select |
| rd_data | output | TW | Selected word |

## Verification
A stored stamp that is wrong, or a flag that fails to clear or that clears itself, shows at the port one cycle after the edge that caused it, provided that port's word is selected. A port that is not being read keeps the error hidden until the host selects it. A fault in the pin synchroniser shows as a sync word that is taken one cycle too early or too late. It can also show as a sync word that ignores one edge direction. Such a fault is visible once the third edge after the transition has passed. The bench compares the selected word against an independent model on every cycle, with random addresses, so a latent fault is exposed within a few cycles.

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
  parameter int NPORT      = 5,
  parameter int WIDE_STAMP = 0,
  parameter int TW         = 64,
  parameter int AW         = $clog2(NPORT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    time_now,
  input  logic [NPORT-1:0] egr_strobe,
  input  logic             pin_in,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [TW-1:0]    rd_data
);
  localparam int SB    = (WIDE_STAMP != 0) ? 32 : 24;
  localparam int TS_LO = (WIDE_STAMP != 0) ? 32 : 8;

  logic [SB-1:0]    stamp [NPORT];
  logic [NPORT-1:0] flag;
  logic [TW-1:0]    sync_ts;
  logic             pin_m, pin_s, pin_d;
  logic             pin_edge;

  assign pin_edge = pin_s ^ pin_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_m   <= 1'b0;
      pin_s   <= 1'b0;
      pin_d   <= 1'b0;
      sync_ts <= '0;
    end else begin
      pin_m <= pin_in;
      pin_s <= pin_m;
      pin_d <= pin_s;
      if (pin_edge) sync_ts <= time_now;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic rd_hit;
    assign rd_hit = rd_en && (rd_addr == AW'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stamp[p] <= '0;
        flag[p]  <= 1'b0;
      end else if (egr_strobe[p]) begin
        stamp[p] <= time_now[SB-1:0];
        flag[p]  <= 1'b1;
      end else if (rd_hit) begin
        flag[p]  <= 1'b0;
      end
    end

    // R2 / R9
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      egr_strobe[p] |=> flag[p] && stamp[p] == $past(time_now[SB-1:0]));
    // R5
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && !egr_strobe[p] |=> !flag[p] && $stable(stamp[p]));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit && !egr_strobe[p] |=> $stable(flag[p]) && $stable(stamp[p]));
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(NPORT)) rd_data = sync_ts;
    for (int i = 0; i < NPORT; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_data[TS_LO +: SB] = stamp[i];
        rd_data[0]           = flag[i];
      end
    end
  end

  // R7
  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> sync_ts == $past(time_now));
  // R8
  a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_edge |=> $stable(sync_ts));
endmodule

// File: tb/sim_ts_capture_unit.sv
module sim_ts_capture_unit;
  localparam int NPORT = 5;
  localparam int AW    = $clog2(NPORT + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [63:0]      time_now = '0;
  logic [NPORT-1:0] egr_strobe = '0;
  logic             pin_in = 1'b0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic [63:0]      rd_n, rd_w;

  always #10 clk = ~clk;

  ts_capture_unit #(.NPORT(NPORT), .WIDE_STAMP(0)) u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .egr_strobe(egr_strobe),
    .pin_in(pin_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_n));
  ts_capture_unit #(.NPORT(NPORT), .WIDE_STAMP(1)) u1 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .egr_strobe(egr_strobe),
    .pin_in(pin_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_w));

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_time [NPORT];
  logic        m_flag [NPORT];
  logic [63:0] m_sync;
  logic        m_p1, m_p2, m_p3;

  function automatic logic [63:0] exp_word(bit wide, int a);
    logic [63:0] w = '0;
    if (a < NPORT) begin
      if (wide) w = {m_time[a][31:0], 31'b0, m_flag[a]};
      else      w = {32'b0, m_time[a][23:0], 7'b0, m_flag[a]};
    end else if (a == NPORT) w = m_sync;
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d got=%h exp=%h", tag, rd_addr, got, exp);
    end
  endtask

  task automatic step(logic [NPORT-1:0] s, logic pin, logic re, int a,
                      logic [63:0] t, string tag);
    egr_strobe = s; pin_in = pin; rd_en = re; rd_addr = AW'(a); time_now = t;
    #1;
    chk({tag, " narrow"}, rd_n, exp_word(0, a));
    chk({tag, " wide"},   rd_w, exp_word(1, a));
    @(posedge clk);
    if (m_p2 ^ m_p3) m_sync = t;
    m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin;
    for (int p = 0; p < NPORT; p++) begin
      if (s[p]) begin m_time[p] = t; m_flag[p] = 1'b1; end
      else if (re && a == p) m_flag[p] = 1'b0;
    end
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [63:0] t1;
    void'($urandom(32'h5eed_0042));
    for (int p = 0; p < NPORT; p++) begin m_time[p] = '0; m_flag[p] = 0; end
    m_sync = '0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8; a++) step('0, 0, 0, a, rnd64(), "R1 R10");

    t1 = 64'hA5A5_1234_89AB_CDEF;
    step(5'b00100, 0, 0, 2, t1, "R2");
    step('0, 0, 0, 2, rnd64(), "R2 R3 R4");
    chk("R3 literal", rd_n, {32'b0, t1[23:0], 7'b0, 1'b1});
    chk("R4 literal", rd_w, {t1[31:0], 31'b0, 1'b1});

    step('0, 0, 1, 2, rnd64(), "R5");
    step('0, 0, 0, 2, rnd64(), "R5");
    chk("R5 literal", rd_n, {32'b0, t1[23:0], 8'b0});

    step(5'b00010, 0, 0, 1, rnd64(), "R6");
    step(5'b00010, 0, 1, 1, rnd64(), "R6");
    step('0, 0, 0, 1, rnd64(), "R6");

    step(5'b00001, 0, 0, 0, rnd64(), "R9");
    step(5'b00001, 0, 0, 0, 64'h0000_0000_00FF_FFFF, "R9");
    step('0, 0, 0, 0, rnd64(), "R9");

    step('0, 1, 0, NPORT, 64'h1, "R7");
    step('0, 1, 0, NPORT, 64'h2, "R7");
    step('0, 1, 0, NPORT, 64'h3, "R7");
    step('0, 1, 0, NPORT, 64'h4, "R7");
    chk("R7 rise literal", rd_n, 64'h3);
    step('0, 1, 1, NPORT, rnd64(), "R8");
    step('0, 0, 0, NPORT, 64'h10, "R7");
    step('0, 0, 0, NPORT, 64'h11, "R7");
    step('0, 0, 0, NPORT, 64'h12, "R7");
    step('0, 0, 0, NPORT, rnd64(), "R7");
    chk("R7 fall literal", rd_w, 64'h12);

    for (int i = 0; i < 3000; i++) begin
      int a = int'($urandom_range(7));
      logic [NPORT-1:0] s = ($urandom_range(3) == 0) ? NPORT'($urandom) : '0;
      logic pn = ($urandom_range(4) == 0) ? ~pin_in : pin_in;
      string tag = (a < NPORT) ? "R2 R5 R6 R9" : (a == NPORT) ? "R7 R8" : "R10";
      step(s, pn, 1'($urandom), a, rnd64(), tag);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule